// File: doc/BRIEF.md
# Bridge Forwarding Window Decoder

This block works out where a device region lands on the upstream side after it passes through a stack of cascaded PCI-to-PCI bridges. Each bridge level supplies its raw window fields: base and limit bytes for I/O, base and limit words for plain memory and for prefetchable memory, and the upper halves that extend those windows. The block turns these into three address windows per level. The limits are filled with ones in their low bits.

A request gives a region's start, its length, its space type and how many bridge levels lie above the device. The request also carries the device's own I/O and memory enable bits. The engine starts from the region's own range. It then narrows that range against the matching window of one bridge level per clock. The result is either a clipped start and size, or an unmapped flag with both values at zero.

The block also decodes configuration writes aimed at a bridge. If a write lands on window fields, the block raises a one-cycle pulse asking the system to re-evaluate every device below that bridge. A level-select input reads back the decoded windows of any level.

Top module: `brw_decoder`

## Requirements
- R1: I/O window, per level. The base is bits 7:4 of the base byte placed at address bits 15:12. When bits 3:0 of that byte equal 1, the 16-bit upper field goes to bits 31:16. The limit is built the same way from the limit byte and its upper field, with bits 11:0 forced to ones. Both are visible on the readback outputs.
- R2: Plain memory window. The base is bits 15:4 of the base word placed at address bits 31:20. The limit is built the same way from the limit word, with bits 19:0 forced to ones.
- R3: Prefetchable window. It is built like the plain memory window. In addition, when bits 3:0 of its base word (or limit word) equal 1, the 32-bit upper field supplies bits 63:32 of that base (or limit).
- R4: Space codes are 0 for I/O, 1 for memory and 2 for prefetchable memory. The working range starts as [start, start+length-1]. For each level 0 to depth-1, the start becomes the larger of itself and that level's window base, and the end becomes the smaller of itself and the window limit. A depth above N is treated as N.
- R5: The result is unmapped in two cases: the space is I/O and the I/O enable is low, or the space is 1 or 2 and the memory enable is low. Space code 3 is also unmapped.
- R6: The result is also unmapped if the length is zero, if start+length-1 wraps past the top of the address space, or if the final start is above the final end. An unmapped result reports start 0 and size 0.
- R7: A mapped result reports the final start, and a size of end - start + 1.
- R8: A request is taken when valid is high and the engine is idle. The busy output stays high until the result appears. The done output pulses for exactly one cycle, min(depth,N)+1 clock edges after the accepting edge. A valid request that arrives while busy is ignored.
- R9: A configuration write covers bytes [addr, addr+len), with len from 1 to 4. If that range overlaps 0x1C–0x1D or 0x20–0x33, a one-cycle rescan pulse appears after the next edge. Any other write gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_space | input | 2 | 0 I/O, 1 memory, 2 prefetchable, 3 reserved |
| req_base | input | 64 | Region start |
| req_size | input | 64 | Region length in bytes |
| req_io_en | input | 1 | Device I/O decode enable |
| req_mem_en | input | 1 | Device memory decode enable |
| req_depth | input | DW | Number of bridge levels above the device |
| win_io_base | input | N*8 | Per-level I/O base byte |
| win_io_limit | input | N*8 | Per-level I/O limit byte |
| win_io_base_hi | input | N*16 | Per-level I/O base upper field |
| win_io_limit_hi | input | N*16 | Per-level I/O limit upper field |
| win_mem_base | input | N*16 | Per-level memory base word |
| win_mem_limit | input | N*16 | Per-level memory limit word |
| win_pf_base | input | N*16 | Per-level prefetchable base word |
| win_pf_limit | input | N*16 | Per-level prefetchable limit word |
| win_pf_base_hi | input | N*32 | Per-level prefetchable base upper dword |
| win_pf_limit_hi | input | N*32 | Per-level prefetchable limit upper dword |
| cfg_wr | input | 1 | Bridge configuration write strobe |
| cfg_addr | input | 8 | Write byte offset |
| cfg_len | input | 3 | Write length in bytes |
| rd_sel | input | LW | Level chosen for readback |
| busy | output | 1 | Engine walking the levels |
| done | output | 1 | Result valid pulse |
| res_unmapped | output | 1 | Region is not reachable |
| res_base | output | 64 | Clipped start |
| res_size | output | 64 | Clipped size |
| rescan | output | 1 | Re-evaluate devices below the bridge |
| rd_io_base | output | 64 | Readback I/O base |
| rd_io_limit | output | 64 | Readback I/O limit |
| rd_mem_base | output | 64 | Readback memory base |
| rd_mem_limit | output | 64 | Readback memory limit |
| rd_pf_base | output | 64 | Readback prefetchable base |
| rd_pf_limit | output | 64 | Readback prefetchable limit |

## Verification
The bench targets the type nibble that switches on the upper fields. A decoder that ignored it would report windows stuck below 64 KiB or 4 GiB, or would take stray upper bits when the nibble is not 1. It also drives depths of zero, full and beyond N, and checks the latency of each. An engine that skipped a level or walked one too many would report too wide a range or a shifted done pulse. Regions with zero length, disabled enables, the reserved space code, and windows that do not overlap the region must all come back unmapped with zero size, not as a huge wrapped size. Write ranges that just touch or just miss the edges of the window fields find off-by-one errors in the rescan decode.

// File: rtl/brw_pkg.sv
package brw_pkg;

  typedef enum logic [1:0] {
    SP_IO  = 2'd0,
    SP_MEM = 2'd1,
    SP_PF  = 2'd2,
    SP_RSV = 2'd3
  } space_e;

  typedef struct packed {
    logic [63:0] lo;
    logic [63:0] hi;
  } win_t;

  localparam logic [3:0] WIDE_TYPE = 4'h1;

  // I/O window edge: nibble to 15:12, optional upper half, limit fill 11:0
  function automatic logic [63:0] io_edge(input logic [7:0] fld,
                                          input logic [15:0] upper,
                                          input logic is_lim);
    logic [63:0] v;
    v = '0;
    v[15:12] = fld[7:4];
    if (fld[3:0] == WIDE_TYPE) v[31:16] = upper;
    if (is_lim) v[11:0] = '1;
    return v;
  endfunction

  // memory window edge: 12 bits to 31:20, limit fill 19:0
  function automatic logic [63:0] mem_edge(input logic [15:0] fld,
                                           input logic is_lim);
    logic [63:0] v;
    v = '0;
    v[31:20] = fld[15:4];
    if (is_lim) v[19:0] = '1;
    return v;
  endfunction

  // prefetchable edge: memory edge plus optional upper dword
  function automatic logic [63:0] pf_edge(input logic [15:0] fld,
                                          input logic [31:0] upper,
                                          input logic is_lim);
    logic [63:0] v;
    v = mem_edge(fld, is_lim);
    if (fld[3:0] == WIDE_TYPE) v[63:32] = upper;
    return v;
  endfunction

  function automatic logic [63:0] max64(input logic [63:0] a, input logic [63:0] b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [63:0] min64(input logic [63:0] a, input logic [63:0] b);
    return (a < b) ? a : b;
  endfunction

  // half-open byte range overlap on a 9-bit scale
  function automatic logic spans(input logic [8:0] a, input logic [8:0] la,
                                 input logic [8:0] s, input logic [8:0] ls);
    return (la != 0) && (a < s + ls) && (s < a + la);
  endfunction

endpackage

// File: rtl/brw_window_fmt.sv
module brw_window_fmt
  import brw_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N*8-1:0]  io_base_b,
  input  logic [N*8-1:0]  io_limit_b,
  input  logic [N*16-1:0] io_base_hi,
  input  logic [N*16-1:0] io_limit_hi,
  input  logic [N*16-1:0] mem_base_w,
  input  logic [N*16-1:0] mem_limit_w,
  input  logic [N*16-1:0] pf_base_w,
  input  logic [N*16-1:0] pf_limit_w,
  input  logic [N*32-1:0] pf_base_hi,
  input  logic [N*32-1:0] pf_limit_hi,
  output win_t            io_w  [N],
  output win_t            mem_w [N],
  output win_t            pf_w  [N]
);

  for (genvar g = 0; g < N; g++) begin : g_lvl
    assign io_w[g].lo  = io_edge(io_base_b[g*8 +: 8], io_base_hi[g*16 +: 16], 1'b0);
    assign io_w[g].hi  = io_edge(io_limit_b[g*8 +: 8], io_limit_hi[g*16 +: 16], 1'b1);
    assign mem_w[g].lo = mem_edge(mem_base_w[g*16 +: 16], 1'b0);
    assign mem_w[g].hi = mem_edge(mem_limit_w[g*16 +: 16], 1'b1);
    assign pf_w[g].lo  = pf_edge(pf_base_w[g*16 +: 16], pf_base_hi[g*32 +: 32], 1'b0);
    assign pf_w[g].hi  = pf_edge(pf_limit_w[g*16 +: 16], pf_limit_hi[g*32 +: 32], 1'b1);
  end

endmodule

// File: rtl/brw_clip_engine.sv
module brw_clip_engine
  import brw_pkg::*;
#(
  parameter int N  = 4,
  parameter int DW = $clog2(N + 1),
  parameter int LW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_space,
  input  logic [63:0]   req_base,
  input  logic [63:0]   req_size,
  input  logic          req_io_en,
  input  logic          req_mem_en,
  input  logic [DW-1:0] req_depth,
  input  win_t          io_w  [N],
  input  win_t          mem_w [N],
  input  win_t          pf_w  [N],
  output logic          busy,
  output logic          done,
  output logic          res_unmapped,
  output logic [63:0]   res_base,
  output logic [63:0]   res_size,
  output logic [63:0]   cur_base,
  output logic [63:0]   cur_limit,
  output logic          blocked
);

  localparam logic [DW-1:0] DMAX = DW'(N);

  logic          busy_q, done_q, unm_q, blk_q;
  logic [DW-1:0] cnt_q, dep_q;
  space_e        sp_q;
  logic [63:0]   cb_q, cl_q, rb_q, rs_q;

  logic [63:0]   in_limit;
  logic          in_blk, accept, finish;
  logic [DW-1:0] in_dep;
  logic [LW-1:0] lvl;
  win_t          sel_w;

  assign in_limit = req_base + req_size - 64'd1;
  assign in_dep   = (req_depth > DMAX) ? DMAX : req_depth;
  assign accept   = req_valid && !busy_q;
  assign finish   = busy_q && (cnt_q == dep_q);
  assign lvl      = LW'(cnt_q);

  always_comb begin
    in_blk = (req_size == 64'd0) || (in_limit < req_base);
    unique case (space_e'(req_space))
      SP_IO:         in_blk = in_blk || !req_io_en;
      SP_MEM, SP_PF: in_blk = in_blk || !req_mem_en;
      default:       in_blk = 1'b1;
    endcase
  end

  always_comb begin
    unique case (sp_q)
      SP_IO:   sel_w = io_w[lvl];
      SP_PF:   sel_w = pf_w[lvl];
      default: sel_w = mem_w[lvl];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      unm_q  <= 1'b0;
      blk_q  <= 1'b0;
      cnt_q  <= '0;
      dep_q  <= '0;
      sp_q   <= SP_IO;
      cb_q   <= '0;
      cl_q   <= '0;
      rb_q   <= '0;
      rs_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        dep_q  <= in_dep;
        sp_q   <= space_e'(req_space);
        blk_q  <= in_blk;
        cb_q   <= req_base;
        cl_q   <= in_limit;
      end else if (finish) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        if (blk_q || (cb_q > cl_q)) begin
          unm_q <= 1'b1;
          rb_q  <= '0;
          rs_q  <= '0;
        end else begin
          unm_q <= 1'b0;
          rb_q  <= cb_q;
          rs_q  <= cl_q - cb_q + 64'd1;
        end
      end else if (busy_q) begin
        cb_q  <= max64(cb_q, sel_w.lo);
        cl_q  <= min64(cl_q, sel_w.hi);
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy         = busy_q;
  assign done         = done_q;
  assign res_unmapped = unm_q;
  assign res_base     = rb_q;
  assign res_size     = rs_q;
  assign cur_base     = cb_q;
  assign cur_limit    = cl_q;
  assign blocked      = blk_q;

endmodule

// File: rtl/brw_touch_detect.sv
module brw_touch_detect
  import brw_pkg::*;
#(
  parameter logic [7:0] IO_OFS  = 8'h1C,
  parameter int         IO_LEN  = 2,
  parameter logic [7:0] MEM_OFS = 8'h20,
  parameter int         MEM_LEN = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_addr,
  input  logic [2:0] cfg_len,
  output logic       rescan
);

  logic hit;

  assign hit = cfg_wr &&
               (spans({1'b0, cfg_addr}, 9'(cfg_len), {1'b0, IO_OFS}, 9'(IO_LEN)) ||
                spans({1'b0, cfg_addr}, 9'(cfg_len), {1'b0, MEM_OFS}, 9'(MEM_LEN)));

  always_ff @(posedge clk) begin
    if (!rst_n) rescan <= 1'b0;
    else        rescan <= hit;
  end

endmodule

// File: rtl/brw_decoder.sv
module brw_decoder
  import brw_pkg::*;
#(
  parameter int N  = 4,
  parameter int DW = $clog2(N + 1),
  parameter int LW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_space,
  input  logic [63:0]   req_base,
  input  logic [63:0]   req_size,
  input  logic          req_io_en,
  input  logic          req_mem_en,
  input  logic [DW-1:0] req_depth,
  input  logic [N*8-1:0]  win_io_base,
  input  logic [N*8-1:0]  win_io_limit,
  input  logic [N*16-1:0] win_io_base_hi,
  input  logic [N*16-1:0] win_io_limit_hi,
  input  logic [N*16-1:0] win_mem_base,
  input  logic [N*16-1:0] win_mem_limit,
  input  logic [N*16-1:0] win_pf_base,
  input  logic [N*16-1:0] win_pf_limit,
  input  logic [N*32-1:0] win_pf_base_hi,
  input  logic [N*32-1:0] win_pf_limit_hi,
  input  logic          cfg_wr,
  input  logic [7:0]    cfg_addr,
  input  logic [2:0]    cfg_len,
  input  logic [LW-1:0] rd_sel,
  output logic          busy,
  output logic          done,
  output logic          res_unmapped,
  output logic [63:0]   res_base,
  output logic [63:0]   res_size,
  output logic          rescan,
  output logic [63:0]   rd_io_base,
  output logic [63:0]   rd_io_limit,
  output logic [63:0]   rd_mem_base,
  output logic [63:0]   rd_mem_limit,
  output logic [63:0]   rd_pf_base,
  output logic [63:0]   rd_pf_limit
);

  win_t        io_w [N];
  win_t        mem_w[N];
  win_t        pf_w [N];
  logic [63:0] eng_cur_base, eng_cur_limit;
  logic        eng_blocked;

  brw_window_fmt #(.N(N)) u_fmt (
    .io_base_b  (win_io_base),
    .io_limit_b (win_io_limit),
    .io_base_hi (win_io_base_hi),
    .io_limit_hi(win_io_limit_hi),
    .mem_base_w (win_mem_base),
    .mem_limit_w(win_mem_limit),
    .pf_base_w  (win_pf_base),
    .pf_limit_w (win_pf_limit),
    .pf_base_hi (win_pf_base_hi),
    .pf_limit_hi(win_pf_limit_hi),
    .io_w       (io_w),
    .mem_w      (mem_w),
    .pf_w       (pf_w)
  );

  brw_clip_engine #(.N(N), .DW(DW), .LW(LW)) u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_space   (req_space),
    .req_base    (req_base),
    .req_size    (req_size),
    .req_io_en   (req_io_en),
    .req_mem_en  (req_mem_en),
    .req_depth   (req_depth),
    .io_w        (io_w),
    .mem_w       (mem_w),
    .pf_w        (pf_w),
    .busy        (busy),
    .done        (done),
    .res_unmapped(res_unmapped),
    .res_base    (res_base),
    .res_size    (res_size),
    .cur_base    (eng_cur_base),
    .cur_limit   (eng_cur_limit),
    .blocked     (eng_blocked)
  );

  brw_touch_detect u_touch (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_wr  (cfg_wr),
    .cfg_addr(cfg_addr),
    .cfg_len (cfg_len),
    .rescan  (rescan)
  );

  assign rd_io_base   = io_w[rd_sel].lo;
  assign rd_io_limit  = io_w[rd_sel].hi;
  assign rd_mem_base  = mem_w[rd_sel].lo;
  assign rd_mem_limit = mem_w[rd_sel].hi;
  assign rd_pf_base   = pf_w[rd_sel].lo;
  assign rd_pf_limit  = pf_w[rd_sel].hi;

endmodule

// File: rtl/brw_decoder_chk.sv
module brw_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        res_unmapped,
  input logic [63:0] res_base,
  input logic [63:0] res_size,
  input logic        rescan,
  input logic        cfg_wr,
  input logic [63:0] eng_cur_base,
  input logic [63:0] eng_cur_limit,
  input logic        eng_blocked
);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy) && !busy); // R8

  AST_RANGE_NARROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |->
      (eng_cur_base >= $past(eng_cur_base)) && (eng_cur_limit <= $past(eng_cur_limit))); // R4

  AST_BLOCKED_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (done && eng_blocked) |-> res_unmapped); // R5

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_unmapped) |-> (res_size == 64'd0) && (res_base == 64'd0)); // R6

  AST_MAPPED_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !res_unmapped) |-> (res_size != 64'd0)); // R7

  AST_RESCAN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rescan |-> $past(cfg_wr)); // R9

endmodule

bind brw_decoder brw_decoder_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .done         (done),
  .res_unmapped (res_unmapped),
  .res_base     (res_base),
  .res_size     (res_size),
  .rescan       (rescan),
  .cfg_wr       (cfg_wr),
  .eng_cur_base (eng_cur_base),
  .eng_cur_limit(eng_cur_limit),
  .eng_blocked  (eng_blocked)
);

// File: tb/brw_decoder_bench.sv
module brw_decoder_bench;

  localparam int N  = 4;
  localparam int DW = $clog2(N + 1);
  localparam int LW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          req_valid = 1'b0;
  logic [1:0]    req_space = '0;
  logic [63:0]   req_base = '0, req_size = '0;
  logic          req_io_en = 1'b0, req_mem_en = 1'b0;
  logic [DW-1:0] req_depth = '0;
  logic          cfg_wr = 1'b0;
  logic [7:0]    cfg_addr = '0;
  logic [2:0]    cfg_len = '0;
  logic [LW-1:0] rd_sel = '0;

  logic [7:0]  t_iob [N], t_iol [N];
  logic [15:0] t_iobh[N], t_iolh[N], t_mb[N], t_ml[N], t_pb[N], t_pl[N];
  logic [31:0] t_pbh [N], t_plh[N];

  logic [N*8-1:0]  f_iob, f_iol;
  logic [N*16-1:0] f_iobh, f_iolh, f_mb, f_ml, f_pb, f_pl;
  logic [N*32-1:0] f_pbh, f_plh;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      f_iob[i*8 +: 8]    = t_iob[i];
      f_iol[i*8 +: 8]    = t_iol[i];
      f_iobh[i*16 +: 16] = t_iobh[i];
      f_iolh[i*16 +: 16] = t_iolh[i];
      f_mb[i*16 +: 16]   = t_mb[i];
      f_ml[i*16 +: 16]   = t_ml[i];
      f_pb[i*16 +: 16]   = t_pb[i];
      f_pl[i*16 +: 16]   = t_pl[i];
      f_pbh[i*32 +: 32]  = t_pbh[i];
      f_plh[i*32 +: 32]  = t_plh[i];
    end
  end

  logic        busy, done, res_unmapped, rescan;
  logic [63:0] res_base, res_size;
  logic [63:0] rd_io_base, rd_io_limit, rd_mem_base, rd_mem_limit, rd_pf_base, rd_pf_limit;

  brw_decoder #(.N(N)) u_brw_decoder (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_space(req_space), .req_base(req_base),
    .req_size(req_size), .req_io_en(req_io_en), .req_mem_en(req_mem_en),
    .req_depth(req_depth),
    .win_io_base(f_iob), .win_io_limit(f_iol),
    .win_io_base_hi(f_iobh), .win_io_limit_hi(f_iolh),
    .win_mem_base(f_mb), .win_mem_limit(f_ml),
    .win_pf_base(f_pb), .win_pf_limit(f_pl),
    .win_pf_base_hi(f_pbh), .win_pf_limit_hi(f_plh),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_len(cfg_len),
    .rd_sel(rd_sel),
    .busy(busy), .done(done), .res_unmapped(res_unmapped),
    .res_base(res_base), .res_size(res_size), .rescan(rescan),
    .rd_io_base(rd_io_base), .rd_io_limit(rd_io_limit),
    .rd_mem_base(rd_mem_base), .rd_mem_limit(rd_mem_limit),
    .rd_pf_base(rd_pf_base), .rd_pf_limit(rd_pf_limit)
  );

  int total = 0;
  int bad = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // bench model of the windows: arithmetic instead of bit slicing
  function automatic logic [63:0] m_io(input int l, input bit lim);
    logic [63:0] v;
    logic [7:0] b;
    logic [15:0] up;
    b  = lim ? t_iol[l] : t_iob[l];
    up = lim ? t_iolh[l] : t_iobh[l];
    v = 64'(b / 16) * 64'd4096;
    if (b % 16 == 1) v = v + 64'(up) * 64'd65536;
    if (lim) v = v + 64'd4095;
    return v;
  endfunction

  function automatic logic [63:0] m_mem(input logic [15:0] w, input bit lim);
    logic [63:0] v;
    v = 64'(w / 16) * 64'd1048576;
    if (lim) v = v + 64'd1048575;
    return v;
  endfunction

  function automatic logic [63:0] m_pf(input int l, input bit lim);
    logic [15:0] w;
    logic [31:0] up;
    logic [63:0] v;
    w  = lim ? t_pl[l] : t_pb[l];
    up = lim ? t_plh[l] : t_pbh[l];
    v = m_mem(w, lim);
    if (w % 16 == 1) v = v + 64'(up) * 64'h1_0000_0000;
    return v;
  endfunction

  function automatic logic [63:0] m_win(input logic [1:0] sp, input int l, input bit lim);
    if (sp == 2'd0) return m_io(l, lim);
    if (sp == 2'd2) return m_pf(l, lim);
    return m_mem(lim ? t_ml[l] : t_mb[l], lim);
  endfunction

  task automatic run_req(input string tag, input logic [1:0] sp, input logic [63:0] b,
                         input logic [63:0] s, input logic ioe, input logic meme,
                         input int dep, input bit intrude);
    logic [63:0] lo, hi, eb, es;
    logic        eu;
    int          d, n;
    d  = (dep > N) ? N : dep;
    lo = b;
    hi = b + s - 64'd1;
    eu = (s == 0) || (hi < b) || (sp == 2'd3) ||
         (sp == 2'd0 && !ioe) || (sp != 2'd0 && !meme);
    for (int l = 0; l < d; l++) begin
      if (m_win(sp, l, 0) > lo) lo = m_win(sp, l, 0);
      if (m_win(sp, l, 1) < hi) hi = m_win(sp, l, 1);
    end
    if (lo > hi) eu = 1'b1;
    eb = eu ? 64'd0 : lo;
    es = eu ? 64'd0 : (hi - lo + 64'd1);
    @(negedge clk);
    req_valid = 1'b1; req_space = sp; req_base = b; req_size = s;
    req_io_en = ioe; req_mem_en = meme; req_depth = DW'(dep);
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 40) begin
      if (intrude && n == 0) begin
        req_valid = 1'b1; req_base = b ^ 64'h0010_0000; req_size = 64'd1;
        req_space = 2'd3; req_depth = '0;
      end else req_valid = 1'b0;
      @(negedge clk);
      n++;
    end
    req_valid = 1'b0;
    check({tag, " R8 latency"}, 64'(n), 64'(d + 1));
    check({tag, " R5 R6 unmapped"}, 64'(res_unmapped), 64'(eu));
    check({tag, " R4 R7 base"}, res_base, eb);
    check({tag, " R7 size"}, res_size, es);
    @(negedge clk);
    check({tag, " R8 done one cycle"}, 64'(done), 64'd0);
  endtask

  task automatic cfg_poke(input logic [7:0] a, input logic [2:0] l, input bit exp);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_len = l;
    @(negedge clk);
    cfg_wr = 1'b0;
    check($sformatf("R9 rescan addr=0x%0h len=%0d", a, l), 64'(rescan), 64'(exp));
    @(negedge clk);
    check("R9 rescan drops", 64'(rescan), 64'd0);
  endtask

  task automatic randomize_windows();
    for (int i = 0; i < N; i++) begin
      t_iob[i]  = 8'(($urandom % 4) * 16 + ($urandom % 2));
      t_iol[i]  = 8'((8 + $urandom % 8) * 16 + ($urandom % 2));
      t_iobh[i] = 16'($urandom % 2);
      t_iolh[i] = 16'($urandom % 2);
      t_mb[i]   = 16'(($urandom % 64) * 16);
      t_ml[i]   = 16'((192 + $urandom % 64) * 16);
      t_pb[i]   = 16'(($urandom % 64) * 16 + ($urandom % 2));
      t_pl[i]   = 16'((192 + $urandom % 64) * 16 + ($urandom % 2));
      t_pbh[i]  = 32'($urandom % 2);
      t_plh[i]  = 32'($urandom % 2);
    end
  endtask

  initial begin
    int seed_v;
    seed_v = $urandom(32'd20240611);
    for (int i = 0; i < N; i++) begin
      t_iob[i] = '0; t_iol[i] = '0; t_iobh[i] = '0; t_iolh[i] = '0;
      t_mb[i] = '0; t_ml[i] = '0; t_pb[i] = '0; t_pl[i] = '0;
      t_pbh[i] = '0; t_plh[i] = '0;
    end
    repeat (3) @(negedge clk);
    check("R8 reset busy", 64'(busy), 64'd0);
    check("R8 reset done", 64'(done), 64'd0);
    check("R9 reset rescan", 64'(rescan), 64'd0);
    rst_n = 1'b1;

    // directed window assembly, level 2
    t_iob[2] = 8'h51; t_iobh[2] = 16'hABCD; t_iol[2] = 8'h90; t_iolh[2] = 16'h1234;
    t_mb[2] = 16'h1230; t_ml[2] = 16'h4567;
    t_pb[2] = 16'h8001; t_pbh[2] = 32'h0000_00FF; t_pl[2] = 16'h9FF2; t_plh[2] = 32'h7777_7777;
    rd_sel = 2'd2;
    @(negedge clk);
    check("R1 io base wide", rd_io_base, 64'hABCD_5000);
    check("R1 io limit narrow", rd_io_limit, 64'h0000_9FFF);
    check("R2 mem base", rd_mem_base, 64'h1230_0000);
    check("R2 mem limit", rd_mem_limit, 64'h456F_FFFF);
    check("R3 pf base wide", rd_pf_base, 64'h0000_00FF_8000_0000);
    check("R3 pf limit narrow", rd_pf_limit, 64'h0000_0000_9FFF_FFFF);

    randomize_windows();
    for (int i = 0; i < N; i++) begin
      rd_sel = LW'(i);
      @(negedge clk);
      check("R1 io base rnd", rd_io_base, m_io(i, 0));
      check("R1 io limit rnd", rd_io_limit, m_io(i, 1));
      check("R2 mem limit rnd", rd_mem_limit, m_mem(t_ml[i], 1));
      check("R3 pf base rnd", rd_pf_base, m_pf(i, 0));
      check("R3 pf limit rnd", rd_pf_limit, m_pf(i, 1));
    end

    // directed corner requests
    run_req("depth0", 2'd1, 64'h0800_0000, 64'h1000, 1, 1, 0, 0);
    run_req("R5 mem off", 2'd1, 64'h0800_0000, 64'h1000, 1, 0, 2, 0);
    run_req("R5 io off", 2'd0, 64'h6000, 64'h100, 0, 1, 2, 0);
    run_req("R5 rsv space", 2'd3, 64'h0800_0000, 64'h1000, 1, 1, 1, 0);
    run_req("R6 size zero", 2'd1, 64'h0800_0000, 64'd0, 1, 1, 1, 0);
    run_req("R6 wraps", 2'd1, 64'hFFFF_FFFF_FFFF_F000, 64'h2000, 1, 1, 0, 0);
    run_req("R6 outside", 2'd1, 64'h7000_0000, 64'h1000, 1, 1, 3, 0);
    run_req("R4 depth over", 2'd1, 64'h0000_0000, 64'h2000_0000, 1, 1, 7, 0);
    run_req("R4 full io", 2'd0, 64'h0, 64'h1_0000_0000, 1, 1, 4, 0);
    run_req("R8 busy ignore", 2'd2, 64'h0500_0000, 64'h0400_0000, 1, 1, 3, 1);

    // constrained random requests
    for (int k = 0; k < 60; k++) begin
      logic [1:0]  sp;
      logic [63:0] b, s;
      if (k % 15 == 0) randomize_windows();
      sp = 2'($urandom % 3);
      if (sp == 2'd0) begin
        b = 64'($urandom % 32'h10000);
        s = 64'(1 + $urandom % 32'h8000);
      end else begin
        b = 64'($urandom % 32'h1000_0000);
        s = 64'(1 + $urandom % 32'h0800_0000);
        if (sp == 2'd2 && ($urandom % 3 == 0)) b = b | 64'h1_0000_0000;
      end
      run_req($sformatf("R4 rnd%0d", k), sp, b, s,
              ($urandom % 8) != 0, ($urandom % 8) != 0, int'($urandom % (N + 2)), 0);
    end

    // rescan decode edges
    cfg_poke(8'h1B, 3'd1, 0);
    cfg_poke(8'h1A, 3'd4, 1);
    cfg_poke(8'h1D, 3'd1, 1);
    cfg_poke(8'h1E, 3'd2, 0);
    cfg_poke(8'h1E, 3'd3, 1);
    cfg_poke(8'h33, 3'd1, 1);
    cfg_poke(8'h34, 3'd4, 0);
    cfg_poke(8'h04, 3'd2, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R8 actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule